// File: doc/BRIEF.md
# LFSR Interval Timer with Chained Interrupt Control

This block is a small interval timer for a control-oriented peripheral. Each time a prescaler wraps, an 8-bit linear-feedback shift register takes one step. Software picks a starting state that lies a known number of steps before a fixed terminal state. When the register enters the terminal state, a timer request latch is set, and the register keeps stepping through its sequence. A rising edge on the external interrupt pin sets a second latch.

A two-bit select field allows at most one of the two latches to request service at a time. The block takes part in a priority daisy chain. While it holds an enabled request, it blocks the chain for devices further down. It answers an acknowledge with a 16-bit vector. For the timer the vector is a base address. For the external source it is that base plus 0x80.

Four register addresses are decoded from a two-bit address: two latched output ports, the select register and the timer state.

An internal state machine has three states:
- `ST_IDLE`: no enabled request.
- `ST_REQ`: the request is raised.
- `ST_VEC`: the vector is presented for one cycle.

Its transitions are:
- `ST_IDLE` goes to `ST_REQ` when an enabled latch is pending.
- `ST_REQ` goes back to `ST_IDLE` when that latch is no longer enabled.
- `ST_REQ` goes to `ST_VEC` on an acknowledge taken while priority-in is high.
- `ST_VEC` goes to `ST_REQ` if an enabled request remains, otherwise to `ST_IDLE`.

Top module: `poly_timer_irq`

## Requirements
- R1: After reset, both output ports are 0x00. The select field is 00 and the timer state is 0x00. `irq_o` and `vec_valid_o` are low, and `pri_out_o` equals `pri_in_i`.
- R2: Register addresses work as follows. Address 0 is port A and address 1 is port B; each write drives `port_a_o` or `port_b_o` and reads back. Address 2 is the select field in bits [1:0], and bits [7:2] read as zero. Address 3 is the timer state.
- R3: A write to address 3 loads the timer state and restarts the prescaler. The first step happens DIV clock edges after the write edge, and each later step follows DIV edges after the previous one (default DIV = 31).
- R4: One step maps state s to {s[6:0], s[7]^s[5]^s[4]^s[3]}. A loaded state of 0x00 stays 0x00.
- R5: The timer latch sets on the same edge on which the state enters the terminal value 0xFF. On the following step the state moves on to the next value in the sequence.
- R6: The external latch sets on the first clock edge that sees `ext_irq_i` high after it was low, whatever the select field holds.
- R7: Select field codes are as follows. 01 lets only the external latch request. 11 lets only the timer latch request. 00 and 10 let neither request. Changing the field never clears a pending latch.
- R8: `irq_o` rises one clock after an enabled latch becomes pending. It falls one clock after that latch stops being enabled.
- R9: `pri_out_o` is high exactly when `pri_in_i` is high and no enabled latch is pending.
- R10: An `ack_i` sampled while `irq_o` and `pri_in_i` are high does four things. It raises `vec_valid_o` for one cycle on the next cycle. It presents `vec_o` = VEC_BASE (default 0x0020) for the timer or VEC_BASE+0x80 for the external source. It clears only the latch that was served. It drops `irq_o`.
- R11: An `ack_i` sampled while `pri_in_i` is low is ignored: no vector is presented and the request stays raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| port_a_o | output | 8 | Latched output port A |
| port_b_o | output | 8 | Latched output port B |
| ext_irq_i | input | 1 | External interrupt input, rising edge |
| pri_in_i | input | 1 | Priority from the device ahead in the chain |
| pri_out_o | output | 1 | Priority to the device behind in the chain |
| irq_o | output | 1 | Interrupt request |
| ack_i | input | 1 | Interrupt acknowledge |
| vec_o | output | 16 | Interrupt vector |
| vec_valid_o | output | 1 | Vector valid, one-cycle pulse |

## Verification
Some properties are checked on every cycle:
- `ST_REQ` is only ever held while the previous cycle had an enabled pending latch.
- Priority-out never rises without priority-in.
- A vector pulse always lasts exactly one cycle.
- A served timer latch is gone on the following cycle.
- The prescaler count stays in range.
- A zero timer state stays frozen.

Other behaviours only the directed scenarios can show, because they depend on a source-independent model of the step rule and on cycle counting from a load:
- the exact step spacing after a load;
- which state sits a given number of steps before 0xFF;
- the vector values;
- that a latch masked by one select code survives until another code lets it through.

// File: rtl/poly_timer_pkg.sv
package poly_timer_pkg;

    typedef enum logic [1:0] {
        SEL_NONE_A = 2'b00,
        SEL_EXT    = 2'b01,
        SEL_NONE_B = 2'b10,
        SEL_TMR    = 2'b11
    } irq_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_VEC  = 2'd2
    } arb_state_e;

    localparam logic [1:0] ADR_PORT_A = 2'd0;
    localparam logic [1:0] ADR_PORT_B = 2'd1;
    localparam logic [1:0] ADR_SELECT = 2'd2;
    localparam logic [1:0] ADR_TIMER  = 2'd3;

    localparam logic [15:0] EXT_VEC_OFFSET = 16'h0080;

endpackage

// File: rtl/poly_timer_prescale.sv
module poly_timer_prescale #(
    parameter int DIV = 31
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic restart_i,
    output logic tick_o
);

    generate
        if (DIV <= 1) begin : g_bypass
            assign tick_o = ~restart_i;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);

            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk_i) begin
                if (rst_i || restart_i) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick_o = (cnt_q == LAST) && !restart_i;

            AST_PRESCALE_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
                cnt_q <= LAST); // R3
        end
    endgenerate

endmodule

// File: rtl/poly_timer_lfsr.sv
module poly_timer_lfsr #(
    parameter int          W     = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] TERM = 8'hFF
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         step_i,
    output logic [W-1:0] state_o,
    output logic         hit_o
);

    logic [W-1:0] state_q;
    logic [W-1:0] next_state;
    logic         fb;

    always_comb begin
        fb         = ^(state_q & TAPS);
        next_state = {state_q[W-2:0], fb};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= '0;
        end else if (load_i) begin
            state_q <= load_val_i;
        end else if (step_i) begin
            state_q <= next_state;
        end
    end

    assign state_o = state_q;
    assign hit_o   = step_i && !load_i && (next_state == TERM);

    AST_ZERO_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == '0 && !load_i) |=> (state_q == '0)); // R4

    AST_HIT_AT_TERM: assert property (@(posedge clk_i) disable iff (rst_i)
        hit_o |=> (state_q == TERM)); // R5

endmodule

// File: rtl/poly_timer_irqctl.sv
module poly_timer_irqctl
    import poly_timer_pkg::*;
#(
    parameter logic [15:0] VEC_BASE = 16'h0020
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  irq_sel_e    sel_i,
    input  logic        tmr_hit_i,
    input  logic        ext_irq_i,
    input  logic        pri_in_i,
    input  logic        ack_i,
    output logic        pri_out_o,
    output logic        irq_o,
    output logic [15:0] vec_o,
    output logic        vec_valid_o
);

    arb_state_e  st_q, st_d;
    logic        tmr_pend_q;
    logic        ext_pend_q;
    logic        ext_prev_q;
    logic        ext_rise;
    logic        req_act;
    logic        take;
    logic [15:0] vec_q;

    assign ext_rise = ext_irq_i && !ext_prev_q;
    assign req_act  = ((sel_i == SEL_EXT) && ext_pend_q) ||
                      ((sel_i == SEL_TMR) && tmr_pend_q);

    // next-state
    always_comb begin
        st_d = st_q;
        take = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (req_act) st_d = ST_REQ;
            end
            ST_REQ: begin
                if (!req_act) begin
                    st_d = ST_IDLE;
                end else if (ack_i && pri_in_i) begin
                    st_d = ST_VEC;
                    take = 1'b1;
                end
            end
            ST_VEC: begin
                st_d = req_act ? ST_REQ : ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= ST_IDLE;
        else       st_q <= st_d;
    end

    // latches and vector capture
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            tmr_pend_q <= 1'b0;
            ext_pend_q <= 1'b0;
            ext_prev_q <= 1'b0;
            vec_q      <= '0;
        end else begin
            ext_prev_q <= ext_irq_i;
            if (tmr_hit_i)                          tmr_pend_q <= 1'b1;
            else if (take && sel_i == SEL_TMR)      tmr_pend_q <= 1'b0;
            if (ext_rise)                           ext_pend_q <= 1'b1;
            else if (take && sel_i == SEL_EXT)      ext_pend_q <= 1'b0;
            if (take) begin
                vec_q <= (sel_i == SEL_EXT) ? (VEC_BASE + EXT_VEC_OFFSET) : VEC_BASE;
            end
        end
    end

    // outputs
    always_comb begin
        irq_o       = (st_q == ST_REQ);
        vec_valid_o = (st_q == ST_VEC);
        vec_o       = vec_q;
        pri_out_o   = pri_in_i && !req_act;
    end

    AST_REQ_NEEDS_SOURCE: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_REQ) |-> $past(req_act)); // R8

    AST_CHAIN_NO_CREATE: assert property (@(posedge clk_i) disable iff (rst_i)
        pri_out_o |-> pri_in_i); // R9

    AST_VEC_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        vec_valid_o |=> !vec_valid_o); // R10

    AST_TMR_SERVED_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        (take && sel_i == SEL_TMR && !tmr_hit_i) |=> !tmr_pend_q); // R10

    AST_BLOCKED_ACK_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
        !pri_in_i |=> !vec_valid_o); // R11

endmodule

// File: rtl/poly_timer_irq.sv
module poly_timer_irq
    import poly_timer_pkg::*;
#(
    parameter int          DIV      = 31,
    parameter int          W        = 8,
    parameter logic [7:0]  TAPS     = 8'hB8,
    parameter logic [7:0]  TERM     = 8'hFF,
    parameter logic [15:0] VEC_BASE = 16'h0020
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic [1:0]  reg_addr_i,
    input  logic        reg_wr_i,
    input  logic [7:0]  reg_wdata_i,
    output logic [7:0]  reg_rdata_o,
    output logic [7:0]  port_a_o,
    output logic [7:0]  port_b_o,
    input  logic        ext_irq_i,
    input  logic        pri_in_i,
    output logic        pri_out_o,
    output logic        irq_o,
    input  logic        ack_i,
    output logic [15:0] vec_o,
    output logic        vec_valid_o
);

    logic [7:0] port_a_q;
    logic [7:0] port_b_q;
    irq_sel_e   sel_q;
    logic       tmr_load;
    logic       tick;
    logic       hit;
    logic [7:0] tmr_state;

    assign tmr_load = reg_wr_i && (reg_addr_i == ADR_TIMER);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            port_a_q <= '0;
            port_b_q <= '0;
            sel_q    <= SEL_NONE_A;
        end else if (reg_wr_i) begin
            unique case (reg_addr_i)
                ADR_PORT_A: port_a_q <= reg_wdata_i;
                ADR_PORT_B: port_b_q <= reg_wdata_i;
                ADR_SELECT: sel_q    <= irq_sel_e'(reg_wdata_i[1:0]);
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (reg_addr_i)
            ADR_PORT_A: reg_rdata_o = port_a_q;
            ADR_PORT_B: reg_rdata_o = port_b_q;
            ADR_SELECT: reg_rdata_o = {6'b0, sel_q};
            default:    reg_rdata_o = tmr_state;
        endcase
    end

    assign port_a_o = port_a_q;
    assign port_b_o = port_b_q;

    poly_timer_prescale #(.DIV(DIV)) u_pre (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (tmr_load),
        .tick_o    (tick)
    );

    poly_timer_lfsr #(.W(W), .TAPS(TAPS), .TERM(TERM)) u_lfsr (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (tmr_load),
        .load_val_i (reg_wdata_i),
        .step_i     (tick),
        .state_o    (tmr_state),
        .hit_o      (hit)
    );

    poly_timer_irqctl #(.VEC_BASE(VEC_BASE)) u_ctl (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .sel_i       (sel_q),
        .tmr_hit_i   (hit),
        .ext_irq_i   (ext_irq_i),
        .pri_in_i    (pri_in_i),
        .ack_i       (ack_i),
        .pri_out_o   (pri_out_o),
        .irq_o       (irq_o),
        .vec_o       (vec_o),
        .vec_valid_o (vec_valid_o)
    );

    AST_IRQ_VEC_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (rst_i)
        !(irq_o && vec_valid_o)); // R10

endmodule

// File: tb/poly_timer_irq_tb_top.sv
module poly_timer_irq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 31;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  reg_addr;
    logic        reg_wr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic [7:0]  port_a, port_b;
    logic        ext_irq, pri_in, pri_out, irq, ack, vec_valid;
    logic [15:0] vec;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    poly_timer_irq dut_i (
        .clk_i(clk), .rst_i(rst), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .port_a_o(port_a),
        .port_b_o(port_b), .ext_irq_i(ext_irq), .pri_in_i(pri_in),
        .pri_out_o(pri_out), .irq_o(irq), .ack_i(ack), .vec_o(vec),
        .vec_valid_o(vec_valid)
    );

    function automatic logic [7:0] step(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    function automatic logic [7:0] before_term(input int k);
        for (int c = 1; c < 256; c++) begin
            logic [7:0] s = 8'(c);
            for (int i = 0; i < k; i++) s = step(s);
            if (s == 8'hFF) return 8'(c);
        end
        return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // returns half a cycle after the write edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_ext();
        @(negedge clk); ext_irq = 1'b1;
        @(negedge clk); ext_irq = 1'b0;
    endtask

    // ack sampled at the next edge; returns half a cycle after it
    task automatic do_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 port_a", port_a, 8'h00);
        chk("R1 port_b", port_b, 8'h00);
        chk("R1 irq", irq, 1'b0);
        chk("R1 vec_valid", vec_valid, 1'b0);
        chk("R1 pri_out", pri_out, pri_in);
        reg_addr = 2'd2; #1; chk("R1 select", reg_rdata, 8'h00);
        reg_addr = 2'd3; #1; chk("R1 timer", reg_rdata, 8'h00);
    endtask

    task automatic t_regmap();
        wr(2'd0, 8'h5A);
        wr(2'd1, 8'hC3);
        chk("R2 port_a pin", port_a, 8'h5A);
        chk("R2 port_b pin", port_b, 8'hC3);
        reg_addr = 2'd0; #1; chk("R2 port_a read", reg_rdata, 8'h5A);
        reg_addr = 2'd1; #1; chk("R2 port_b read", reg_rdata, 8'hC3);
        wr(2'd2, 8'hFF);
        reg_addr = 2'd2; #1; chk("R2 select read", reg_rdata, 8'h03);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_zero_hold();
        wr(2'd3, 8'h00);
        repeat (3*DIV) @(negedge clk);
        reg_addr = 2'd3; #1; chk("R4 zero holds", reg_rdata, 8'h00);
    endtask

    task automatic t_spacing();
        wr(2'd3, 8'h01);
        reg_addr = 2'd3;
        repeat (DIV-1) @(negedge clk);
        chk("R3 no step before DIV", reg_rdata, 8'h01);
        @(negedge clk);
        chk("R3 R4 first step", reg_rdata, step(8'h01));
        repeat (DIV-1) @(negedge clk);
        chk("R3 hold between steps", reg_rdata, step(8'h01));
        @(negedge clk);
        chk("R3 R4 second step", reg_rdata, step(step(8'h01)));
        wr(2'd3, 8'h00);
    endtask

    task automatic t_timer_irq();
        pri_in = 1'b1;
        wr(2'd2, 8'h03);
        wr(2'd3, before_term(3));
        reg_addr = 2'd3;
        repeat (3*DIV) @(negedge clk);
        chk("R5 reached terminal", reg_rdata, 8'hFF);
        chk("R9 pri_out blocked", pri_out, 1'b0);
        chk("R8 irq not yet", irq, 1'b0);
        @(negedge clk);
        chk("R8 irq raised", irq, 1'b1);
        repeat (DIV-1) @(negedge clk);
        chk("R5 continues past terminal", reg_rdata, step(8'hFF));
        do_ack();
        chk("R10 vec_valid", vec_valid, 1'b1);
        chk("R10 timer vector", vec, 16'h0020);
        chk("R10 irq dropped", irq, 1'b0);
        chk("R10 R9 pri_out restored", pri_out, 1'b1);
        @(negedge clk);
        chk("R10 vec_valid one cycle", vec_valid, 1'b0);
        wr(2'd3, 8'h00);
    endtask

    task automatic t_ext_irq();
        pulse_ext();
        @(negedge clk);
        chk("R7 ext masked by 11", irq, 1'b0);
        chk("R7 pri_out with masked ext", pri_out, 1'b1);
        wr(2'd2, 8'h01);
        chk("R6 R9 pri_out blocked by ext", pri_out, 1'b0);
        @(negedge clk);
        chk("R6 R8 ext irq raised", irq, 1'b1);
        pri_in = 1'b0;
        do_ack();
        chk("R11 no vector while blocked", vec_valid, 1'b0);
        chk("R11 irq kept", irq, 1'b1);
        chk("R9 pri_out low with pri_in low", pri_out, 1'b0);
        pri_in = 1'b1;
        do_ack();
        chk("R10 ext vec_valid", vec_valid, 1'b1);
        chk("R10 ext vector", vec, 16'h00A0);
        @(negedge clk);
        chk("R10 ext irq cleared", irq, 1'b0);
    endtask

    task automatic t_none_codes();
        wr(2'd2, 8'h02);
        pulse_ext();
        @(negedge clk);
        chk("R7 code 10 no irq", irq, 1'b0);
        chk("R7 code 10 pri_out", pri_out, 1'b1);
        wr(2'd2, 8'h00);
        @(negedge clk);
        chk("R7 code 00 no irq", irq, 1'b0);
        wr(2'd2, 8'h01);
        @(negedge clk);
        chk("R7 ext latch preserved", irq, 1'b1);
        do_ack();
        chk("R10 ext vector again", vec, 16'h00A0);
        @(negedge clk);
    endtask

    task automatic t_both_pending();
        wr(2'd2, 8'h00);
        wr(2'd3, before_term(1));
        repeat (DIV+2) @(negedge clk);
        wr(2'd3, 8'h00);
        pulse_ext();
        @(negedge clk);
        chk("R7 timer latch masked by 00", irq, 1'b0);
        wr(2'd2, 8'h03);
        @(negedge clk);
        chk("R7 R8 timer latch preserved", irq, 1'b1);
        do_ack();
        chk("R10 timer vector first", vec, 16'h0020);
        @(negedge clk);
        chk("R10 timer cleared", irq, 1'b0);
        chk("R10 pri_out after timer served", pri_out, 1'b1);
        wr(2'd2, 8'h01);
        chk("R10 ext untouched by timer ack", pri_out, 1'b0);
        @(negedge clk);
        chk("R10 ext still requests", irq, 1'b1);
        do_ack();
        chk("R10 ext vector second", vec, 16'h00A0);
        wr(2'd2, 8'h00);
        @(negedge clk);
        chk("R8 irq falls when disabled", irq, 1'b0);
    endtask

    initial begin
        rst = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
        ext_irq = 1'b0; pri_in = 1'b1; ack = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_zero_hold();
        t_spacing();
        t_timer_irq();
        t_ext_irq();
        t_none_codes();
        t_both_pending();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule